// File: doc/BRIEF.md
# Downstream FPGA Configuration Sequencer

This block loads a configuration image into a downstream FPGA that is configured as a slave. After reset it holds the target's INIT line low through an open-drain driver, so the target cannot start its own power-on configuration. A start request, given while the configuration port is reported present, does the following in order:

- It releases INIT and raises the optional enable output.
- It drives the active-low PROGRAM line low for a fixed number of cycles.
- It waits for the target to raise INIT.
- It copies every byte of a valid/ready byte stream to the configuration data port.
- It waits for the target to raise DONE.

Separate watchdog windows guard the INIT wait and the DONE wait. The outcome is reported as a two-bit code and a sticky finished flag.

The controller has five states. IDLE goes to PULSE on a start request while the port is present. PULSE goes to INIT_WAIT when the pulse width has elapsed. INIT_WAIT goes to STREAM once the synchronised INIT reads high, or straight to DONE_WAIT if the byte count is zero. It falls back to IDLE with code 2 when the INIT window expires. STREAM goes to DONE_WAIT when the last byte is accepted. DONE_WAIT returns to IDLE with code 0 when the synchronised DONE reads high, or with code 3 when the DONE window expires. A start request in IDLE while the port is absent stays in IDLE and reports code 1.

INIT and DONE each pass through a two-flop synchroniser before the state machine samples them. The pulse width and both windows are parameters counted in clock cycles.

Top module: `fpga_cfg_seq`

## Requirements
- R1: After reset, init_oe_o is 1 (INIT held low), prog_n_o is 1, and en_o, busy_o, fin_o, s_ready_o and cfg_wr_o are 0, with result_o 0. init_oe_o falls only on an accepted start, and it never rises again until the next reset.
- R2: After an accepted start, prog_n_o is low for exactly PULSE_CYC consecutive cycles, starting the cycle after the start, and then returns high.
- R3: If the synchronised INIT does not read high, the run ends exactly INIT_TMO cycles after prog_n_o rises. It ends with result_o = 2 and without any configuration write.
- R4: s_ready_o is high only in STREAM. Each accepted byte (s_valid_i and s_ready_o high at a clock edge) produces one cycle of cfg_wr_o in the next cycle, with cfg_data_o equal to that byte. Bytes are written in arrival order, exactly length_i of them, and a length of 0 skips streaming.
- R5: After the last write, if DONE never reads high, the run ends exactly DONE_TMO cycles after the last cfg_wr_o, with result_o = 3. If DONE reads high within the window, the run ends with result_o = 0.
- R6: A start while port_present_i is 0 and busy_o is 0 sets fin_o = 1 and result_o = 1 in the next cycle. busy_o stays 0, and init_oe_o, prog_n_o and en_o keep their values.
- R7: With USE_ENABLE set, en_o is high in exactly the cycles in which busy_o is high, so it falls at the end of a run whatever the result.
- R8: busy_o is high from the cycle after an accepted start until the cycle the result is latched, and fin_o is 0 in those cycles. fin_o and result_o hold until the next start. A start request while busy_o is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled in IDLE |
| port_present_i | input | 1 | A configuration port exists for the target |
| length_i | input | LEN_W | Image length in bytes, captured at start |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | DATA_W | Stream byte |
| s_ready_o | output | 1 | Stream ready, high in STREAM only |
| cfg_data_o | output | DATA_W | Byte presented to the configuration port |
| cfg_wr_o | output | 1 | Single-cycle write strobe for the configuration port |
| prog_n_o | output | 1 | Active-low PROGRAM line |
| init_oe_o | output | 1 | Open-drain enable for INIT; 1 pulls INIT low |
| init_i | input | 1 | INIT level read from the pin |
| done_i | input | 1 | DONE level read from the pin |
| en_o | output | 1 | Target enable, high during a run |
| busy_o | output | 1 | Run in progress |
| fin_o | output | 1 | Sticky finished flag |
| result_o | output | 2 | 0 success, 1 no port, 2 no INIT, 3 no DONE |

## Verification
The hardest cases to reach are the two timeout exits, because each one needs the target model to stay silent for a full window. The cycle count must then be compared to the parameter exactly, measured from the right edge: the rise of PROGRAM for the INIT window and the last write strobe for the DONE window. The bench sets both windows short. It models the target as an open-drain INIT that it can keep low forever, and a DONE it can withhold. It measures the elapsed cycles at the ports. Random runs vary the stream gaps, lengths and target response delays, and directed runs cover the zero-length image, the absent port and a start injected mid-run.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_INIT_WAIT,
        ST_STREAM,
        ST_DONE_WAIT
    } fcs_state_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_NO_PORT = 2'd1,
        RES_NO_INIT = 2'd2,
        RES_NO_DONE = 2'd3
    } fcs_result_e;

endpackage

// File: rtl/fcs_sync.sv
module fcs_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_i;
            stage2 <= stage1;
        end
    end

    assign q_o = stage2;
endmodule

// File: rtl/fcs_span_timer.sv
module fcs_span_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic hit_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (run_i)
            cnt <= cnt + CW'(1);
        else
            cnt <= '0;
    end

    // high in the LIMIT-th consecutive cycle of run_i
    assign hit_o = run_i && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
    import fcs_pkg::*;
#(
    parameter int PULSE_CYC  = 200,
    parameter int INIT_TMO   = 10000000,
    parameter int DONE_TMO   = 100000000,
    parameter bit USE_ENABLE = 1'b1,
    parameter int LEN_W      = 32,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              port_present_i,
    input  logic [LEN_W-1:0]  length_i,
    input  logic              s_valid_i,
    input  logic [DATA_W-1:0] s_data_i,
    output logic              s_ready_o,
    output logic [DATA_W-1:0] cfg_data_o,
    output logic              cfg_wr_o,
    output logic              prog_n_o,
    output logic              init_oe_o,
    input  logic              init_i,
    input  logic              done_i,
    output logic              en_o,
    output logic              busy_o,
    output logic              fin_o,
    output logic [1:0]        result_o
);
    localparam int N_SYNC = 2;

    fcs_state_e        state, state_nx;
    logic [LEN_W-1:0]  remaining;
    logic [N_SYNC-1:0] pins_s;
    logic              init_s, done_s;
    logic              pulse_hit, init_hit, done_hit;
    logic              go, refuse, take;
    logic              finish;
    fcs_result_e       finish_code;

    fcs_sync #(.W(N_SYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({done_i, init_i}),
        .q_o   (pins_s)
    );
    assign init_s = pins_s[0];
    assign done_s = pins_s[1];

    fcs_span_timer #(.LIMIT(PULSE_CYC)) u_pulse_tmr (
        .clk (clk), .rst_n (rst_n),
        .run_i (state == ST_PULSE), .hit_o (pulse_hit)
    );
    fcs_span_timer #(.LIMIT(INIT_TMO)) u_init_tmr (
        .clk (clk), .rst_n (rst_n),
        .run_i (state == ST_INIT_WAIT), .hit_o (init_hit)
    );
    fcs_span_timer #(.LIMIT(DONE_TMO)) u_done_tmr (
        .clk (clk), .rst_n (rst_n),
        .run_i (state == ST_DONE_WAIT), .hit_o (done_hit)
    );

    assign busy_o    = (state != ST_IDLE);
    assign s_ready_o = (state == ST_STREAM);
    assign take      = s_valid_i && s_ready_o;
    assign go        = (state == ST_IDLE) && start_i && port_present_i;
    assign refuse    = (state == ST_IDLE) && start_i && !port_present_i;

    // next state and the exit reason of a run
    always_comb begin
        state_nx    = state;
        finish      = 1'b0;
        finish_code = RES_OK;
        unique case (state)
            ST_IDLE: begin
                if (go)
                    state_nx = ST_PULSE;
            end
            ST_PULSE: begin
                if (pulse_hit)
                    state_nx = ST_INIT_WAIT;
            end
            ST_INIT_WAIT: begin
                if (init_s)
                    state_nx = (remaining == '0) ? ST_DONE_WAIT : ST_STREAM;
                else if (init_hit) begin
                    state_nx    = ST_IDLE;
                    finish      = 1'b1;
                    finish_code = RES_NO_INIT;
                end
            end
            ST_STREAM: begin
                if (take && remaining == LEN_W'(1))
                    state_nx = ST_DONE_WAIT;
            end
            ST_DONE_WAIT: begin
                if (done_s || done_hit) begin
                    state_nx    = ST_IDLE;
                    finish      = 1'b1;
                    finish_code = done_s ? RES_OK : RES_NO_DONE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register and byte counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            remaining <= '0;
        end else begin
            state <= state_nx;
            if (go)
                remaining <= length_i;
            else if (take)
                remaining <= remaining - LEN_W'(1);
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_n_o   <= 1'b1;
            init_oe_o  <= 1'b1;
            en_o       <= 1'b0;
            cfg_wr_o   <= 1'b0;
            cfg_data_o <= '0;
            fin_o      <= 1'b0;
            result_o   <= RES_OK;
        end else begin
            prog_n_o <= (state_nx != ST_PULSE);
            en_o     <= USE_ENABLE && (state_nx != ST_IDLE);
            cfg_wr_o <= take;
            if (take)
                cfg_data_o <= s_data_i;
            if (go) begin
                init_oe_o <= 1'b0;
                fin_o     <= 1'b0;
            end else if (refuse) begin
                fin_o    <= 1'b1;
                result_o <= RES_NO_PORT;
            end else if (finish) begin
                fin_o    <= 1'b1;
                result_o <= finish_code;
            end
        end
    end
endmodule

// File: rtl/fcs_chk.sv
module fcs_chk #(
    parameter int PULSE = 200
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       port_present_i,
    input logic       s_valid_i,
    input logic [7:0] s_data_i,
    input logic       s_ready_o,
    input logic [7:0] cfg_data_o,
    input logic       cfg_wr_o,
    input logic       prog_n_o,
    input logic       init_oe_o,
    input logic       en_o,
    input logic       busy_o,
    input logic       fin_o,
    input logic [1:0] result_o
);
    int low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_cnt <= 0;
        else
            low_cnt <= prog_n_o ? 0 : low_cnt + 1;
    end

    // R1
    init_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_oe_o) |-> $past(start_i && port_present_i && !busy_o));

    // R1
    init_stays_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_oe_o |=> !init_oe_o);

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_n_o) |-> (low_cnt == PULSE));

    // R4
    ready_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> (busy_o && prog_n_o && !fin_o));

    // R4
    wr_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_o |-> $past(s_valid_i && s_ready_o));

    // R4
    wr_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_o |-> (cfg_data_o == $past(s_data_i)));

    // R6
    no_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !port_present_i && !busy_o) |=> (fin_o && result_o == 2'd1 && !busy_o));

    // R7
    en_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !en_o);

    // R8
    fin_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !fin_o);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(result_o));
endmodule

bind fpga_cfg_seq fcs_chk #(.PULSE(PULSE_CYC)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .port_present_i (port_present_i),
    .s_valid_i      (s_valid_i),
    .s_data_i       (s_data_i),
    .s_ready_o      (s_ready_o),
    .cfg_data_o     (cfg_data_o),
    .cfg_wr_o       (cfg_wr_o),
    .prog_n_o       (prog_n_o),
    .init_oe_o      (init_oe_o),
    .en_o           (en_o),
    .busy_o         (busy_o),
    .fin_o          (fin_o),
    .result_o       (result_o)
);

// File: tb/fpga_cfg_seq_tb.sv
`timescale 1ns/1ps
module fpga_cfg_seq_tb;
    localparam int PULSE = 20;
    localparam int ITMO  = 60;
    localparam int DTMO  = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        port_present_i = 1'b1;
    logic [31:0] length_i = '0;
    logic        s_valid_i = 1'b0;
    logic [7:0]  s_data_i = '0;
    logic        s_ready_o, cfg_wr_o, prog_n_o, init_oe_o, en_o, busy_o, fin_o;
    logic [7:0]  cfg_data_o;
    logic [1:0]  result_o;
    logic        init_i, done_i;

    int checks = 0;
    int errors = 0;

    logic [7:0] mem [64];
    int len_cur = 0, idx = 0, wr_cnt = 0, data_bad = 0;
    int plow = 0, init_win = 0, done_win = 0, en_bad = 0;
    int init_delay = -1, done_delay = -1, icnt = 0, dcnt = 0;
    logic init_model = 1'b0, done_model = 1'b0, armed = 1'b0;

    assign init_i = init_oe_o ? 1'b0 : init_model;
    assign done_i = done_model;

    always #2.5 clk = ~clk;

    fpga_cfg_seq #(
        .PULSE_CYC (PULSE), .INIT_TMO (ITMO), .DONE_TMO (DTMO),
        .USE_ENABLE (1'b1), .LEN_W (32), .DATA_W (8)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i),
        .port_present_i (port_present_i), .length_i (length_i),
        .s_valid_i (s_valid_i), .s_data_i (s_data_i), .s_ready_o (s_ready_o),
        .cfg_data_o (cfg_data_o), .cfg_wr_o (cfg_wr_o), .prog_n_o (prog_n_o),
        .init_oe_o (init_oe_o), .init_i (init_i), .done_i (done_i),
        .en_o (en_o), .busy_o (busy_o), .fin_o (fin_o), .result_o (result_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_code(input bit present, input int idel, input int ddel);
        if (!present) return 1;
        if (idel < 0) return 2;
        if (ddel < 0) return 3;
        return 0;
    endfunction

    // stream source, target model and port monitors, all at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_wr_o) begin
                if (cfg_data_o !== mem[idx]) data_bad++;
                idx++;
                wr_cnt++;
            end
            s_data_i  = mem[idx % 64];
            s_valid_i = (idx < len_cur) && ($urandom % 4 != 0);
            if (!prog_n_o) plow++;
            if (busy_o && prog_n_o && plow > 0 && !init_model) init_win++;
            if (busy_o && len_cur > 0 && wr_cnt == len_cur && init_model) done_win++;
            if (busy_o !== en_o) en_bad++;
            if (!prog_n_o) begin
                armed = 1'b1; init_model = 1'b0; done_model = 1'b0;
                icnt = 0; dcnt = 0;
            end else if (armed) begin
                if (init_delay >= 0 && icnt >= init_delay) init_model = 1'b1;
                icnt++;
                if (init_model && wr_cnt == len_cur && done_delay >= 0) begin
                    if (dcnt >= done_delay) done_model = 1'b1;
                    dcnt++;
                end
            end
        end
    end

    task automatic run(input int len, input int idel, input int ddel,
                       input bit present, input bit poke);
        int ec;
        logic oe_before;
        logic [1:0] res_hold;
        ec = exp_code(present, idel, ddel);
        for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
        @(negedge clk);
        len_cur = len; idx = 0; wr_cnt = 0; data_bad = 0;
        plow = 0; init_win = 0; done_win = 0; en_bad = 0;
        init_delay = idel; done_delay = ddel; armed = 1'b0;
        oe_before = init_oe_o;
        port_present_i = present; length_i = 32'(len); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; port_present_i = 1'b1;
        if (!present) begin
            check(fin_o === 1'b1 && result_o === 2'd1, "R6", "no-port result", int'(result_o), 1);
            check(busy_o === 1'b0 && prog_n_o === 1'b1 && en_o === 1'b0 && init_oe_o === oe_before,
                  "R6", "pins untouched", int'({busy_o, prog_n_o, en_o, init_oe_o}),
                  int'({1'b0, 1'b1, 1'b0, oe_before}));
            return;
        end
        check(busy_o === 1'b1 && fin_o === 1'b0, "R8", "busy after start", int'({busy_o, fin_o}), 2);
        if (poke) begin
            for (int n = 0; n < 1000 && !(prog_n_o && plow > 0); n++) @(negedge clk);
            port_present_i = 1'b0; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0; port_present_i = 1'b1;
        end
        for (int n = 0; n < 5000 && !fin_o; n++) @(negedge clk);
        check(fin_o === 1'b1 && busy_o === 1'b0, "R8", "run finished", int'({fin_o, busy_o}), 2);
        check(int'(result_o) == ec, (ec == 2) ? "R3" : "R5", "result code", int'(result_o), ec);
        check(plow == PULSE, "R2", "PROGRAM low cycles", plow, PULSE);
        check(wr_cnt == ((ec == 2) ? 0 : len), "R4", "write count", wr_cnt, (ec == 2) ? 0 : len);
        check(data_bad == 0, "R4", "byte order/value mismatches", data_bad, 0);
        check(init_oe_o === 1'b0, "R1", "INIT released", int'(init_oe_o), 0);
        check(en_bad == 0, "R7", "enable/busy mismatch cycles", en_bad, 0);
        if (ec == 2) check(init_win == ITMO, "R3", "INIT window cycles", init_win, ITMO);
        if (ec == 3) check(done_win == DTMO, "R5", "DONE window cycles", done_win, DTMO);
        res_hold = result_o;
        repeat (5) @(negedge clk);
        check(fin_o === 1'b1 && result_o === res_hold, "R8", "result held", int'(result_o), int'(res_hold));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        check(init_oe_o === 1'b1 && prog_n_o === 1'b1 && en_o === 1'b0 && busy_o === 1'b0
              && fin_o === 1'b0 && s_ready_o === 1'b0 && cfg_wr_o === 1'b0 && result_o === 2'd0,
              "R1", "reset state", int'({init_oe_o, prog_n_o, en_o, busy_o, fin_o}), 24);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run(8, 5, 3, 1'b0, 1'b0);        // R6 absent port, INIT still held
        check(init_oe_o === 1'b1, "R1", "INIT held after refused start", int'(init_oe_o), 1);
        run(12, 4, 2, 1'b1, 1'b0);       // R4 basic load
        run(0, 3, 5, 1'b1, 1'b0);        // R4 zero length
        run(1, 0, 0, 1'b1, 1'b0);        // R4 single byte
        run(10, -1, 0, 1'b1, 1'b0);      // R3 INIT timeout
        run(7, 6, -1, 1'b1, 1'b0);       // R5 DONE timeout
        run(20, 10, 8, 1'b1, 1'b1);      // R8 start while busy ignored
        for (int k = 0; k < 8; k++)
            run(1 + int'($urandom % 40), int'($urandom % 30), int'($urandom % 30), 1'b1, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule